// File: doc/BRIEF.md
# Thermal Threshold Interrupt Controller

This block watches an 8-bit temperature code that a sensor delivers once per sample strobe. It compares each new code with the code from the previous sample, against a set of programmable trip levels. Every level has an upward threshold and its own separate downward threshold. A crossing in either direction sets a sticky status bit in its own bit group. Software enables status bits into a single interrupt line and clears them by writing ones. A control field powers the sensing core on or off. An emulation register can replace the live sensor code with a programmed code after a chosen number of sample ticks, so that trip handling can be exercised without heating the die.

A flat register port with an address, a write strobe, write data and combinational read data stands in for the system bus. The interrupt output is level-sensitive.

Top module: `therm_irq_ctrl`

## Requirements
- R1: After synchronous reset, control reads 2 (core off), status reads 0, the temperature register reads 0, the threshold, enable and emulation registers read 0, and irq is low.
- R2: The core is on only while control bits [1:0] equal 3. While it is off, sample strobes leave the temperature register and the interrupt status unchanged, and irq stays low whatever the enables hold. The status register (0x28) reads 1 in bit 0 while the core is on.
- R3: On each sample strobe taken while the core is on, the temperature register (0x40, bits [7:0]) loads the selected code. It holds its value at all other times.
- R4: The upward threshold of level i is byte [8i+7:8i] of register 0x50. An upward event for level i sets status bit 4i when the new code is greater than or equal to the threshold and the previous code was below it.
- R5: The downward threshold of level i is byte [8i+7:8i] of register 0x54. A downward event for level i sets status bit 16+4i when the new code is below the threshold and the previous code was greater than or equal to it. A threshold byte of zero produces no downward event.
- R6: Status bits (0x74) stay set until cleared. Writing register 0x78 clears exactly the status bits written as one, and zero bits have no effect. A code that stays beyond a threshold does not raise a new event.
- R7: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R8: The enable register (0x70) stores only bits 4i and 16+4i. irq is high when the core is on and any status bit is set together with its enable bit. Enables never gate the setting of status.
- R9: Emulation register 0x80 holds an enable flag at bit 0, a code at bits [15:8] and a delay at bits [31:16]. A write loads a tick counter with the delay. Each accepted sample with a nonzero count decrements the counter. While the flag is set and the count is zero, the emulated code replaces the sensor code. Clearing the flag returns to the sensor code.
- R10: The threshold, enable, control and emulation registers read back what was written, subject to the enable mask. Unmapped addresses and the clear register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle strobe marking a new sensor code |
| sensor_code | input | 8 | Live temperature code from the sensor |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
Two functions can act on the same status bit in one cycle: a threshold crossing that sets it and a clear write that resets it. The bench provokes this by asserting a sample strobe that crosses level 0 upward in the same cycle as a write of one to that bit of the clear register. Its reference model applies the clear first and the event second, so it expects the bit and the interrupt to remain set. A clear of an unrelated bit in the same cycle must still take effect. A reference model running alongside the design is compared with the read data and irq after every clock edge.

// File: rtl/therm_pkg.sv
package therm_pkg;

    localparam int CODE_W     = 8;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int MAX_LEV    = DATA_W / CODE_W;
    localparam int LANE       = 4;
    localparam int FALL_OFS   = 16;
    localparam int EMUL_DLY_W = 16;

    localparam logic [1:0] CORE_ON_VAL  = 2'd3;
    localparam logic [1:0] CORE_OFF_VAL = 2'd2;

    localparam logic [ADDR_W-1:0] A_CTRL = 8'h20;
    localparam logic [ADDR_W-1:0] A_CORE = 8'h28;
    localparam logic [ADDR_W-1:0] A_TEMP = 8'h40;
    localparam logic [ADDR_W-1:0] A_RISE = 8'h50;
    localparam logic [ADDR_W-1:0] A_FALL = 8'h54;
    localparam logic [ADDR_W-1:0] A_IEN  = 8'h70;
    localparam logic [ADDR_W-1:0] A_IST  = 8'h74;
    localparam logic [ADDR_W-1:0] A_ICLR = 8'h78;
    localparam logic [ADDR_W-1:0] A_EMUL = 8'h80;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [EMUL_DLY_W-1:0] delay;
        code_t                 code;
        logic [6:0]            rsvd;
        logic                  on;
    } emul_t;

    function automatic logic [DATA_W-1:0] ien_mask(int n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[LANE*i]          = 1'b1;
            m[FALL_OFS+LANE*i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/therm_regs.sv
module therm_regs
    import therm_pkg::*;
#(
    parameter int N_LEV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sample_stb,
    input  code_t             sensor_code,
    output logic              core_on,
    output logic [1:0]        ctrl_q,
    output logic [DATA_W-1:0] rise_q,
    output logic [DATA_W-1:0] fall_q,
    output logic [DATA_W-1:0] ien_q,
    output emul_t             emul_q,
    output code_t             temp_q,
    output code_t             cur_code,
    output logic              accept
);

    localparam logic [DATA_W-1:0] IEN_MASK = ien_mask(N_LEV);

    logic [EMUL_DLY_W-1:0] tick_cnt;
    logic                  emul_act;
    logic                  emul_wr;

    assign core_on  = (ctrl_q == CORE_ON_VAL);
    assign accept   = sample_stb && core_on;
    assign emul_wr  = wr_en && (wr_addr == A_EMUL);
    assign emul_act = emul_q.on && (tick_cnt == '0);
    assign cur_code = emul_act ? emul_q.code : sensor_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CORE_OFF_VAL;
            rise_q <= '0;
            fall_q <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:  ctrl_q <= wr_data[1:0];
                A_RISE:  rise_q <= wr_data;
                A_FALL:  fall_q <= wr_data;
                A_IEN:   ien_q  <= wr_data & IEN_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            emul_q   <= '0;
            tick_cnt <= '0;
        end else if (emul_wr) begin
            emul_q   <= emul_t'(wr_data);
            tick_cnt <= wr_data[DATA_W-1 -: EMUL_DLY_W];
        end else if (accept && (tick_cnt != '0)) begin
            tick_cnt <= tick_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
        end else if (accept) begin
            temp_q <= cur_code;
        end
    end

    p_temp_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && core_on) |=> $stable(temp_q));

    p_cnt_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (tick_cnt == '0 && !emul_wr) |=> (tick_cnt == '0));

endmodule

// File: rtl/therm_cmp.sv
module therm_cmp
    import therm_pkg::*;
#(
    parameter int N_LEV = 4
) (
    input  logic              fire,
    input  code_t             prev_code,
    input  code_t             new_code,
    input  logic [DATA_W-1:0] rise_thr,
    input  logic [DATA_W-1:0] fall_thr,
    output logic [N_LEV-1:0]  rise_ev,
    output logic [N_LEV-1:0]  fall_ev
);

    for (genvar i = 0; i < N_LEV; i++) begin : g_lvl
        code_t up_t;
        code_t dn_t;
        assign up_t = rise_thr[CODE_W*i +: CODE_W];
        assign dn_t = fall_thr[CODE_W*i +: CODE_W];
        assign rise_ev[i] = fire && (new_code >= up_t) && (prev_code < up_t);
        assign fall_ev[i] = fire && (dn_t != '0) && (new_code < dn_t) && (prev_code >= dn_t);
    end

endmodule

// File: rtl/therm_stat.sv
module therm_stat #(
    parameter int N_LEV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_LEV-1:0] rise_ev,
    input  logic [N_LEV-1:0] fall_ev,
    input  logic             clr_we,
    input  logic [N_LEV-1:0] clr_rise,
    input  logic [N_LEV-1:0] clr_fall,
    input  logic [N_LEV-1:0] en_rise,
    input  logic [N_LEV-1:0] en_fall,
    input  logic             core_on,
    output logic [N_LEV-1:0] rise_st,
    output logic [N_LEV-1:0] fall_st,
    output logic             irq
);

    logic [N_LEV-1:0] kill_r;
    logic [N_LEV-1:0] kill_f;

    assign kill_r = clr_we ? clr_rise : '0;
    assign kill_f = clr_we ? clr_fall : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_st <= '0;
            fall_st <= '0;
        end else begin
            rise_st <= (rise_st & ~kill_r) | rise_ev;
            fall_st <= (fall_st & ~kill_f) | fall_ev;
        end
    end

    assign irq = core_on && ((|(rise_st & en_rise)) || (|(fall_st & en_fall)));

    for (genvar i = 0; i < N_LEV; i++) begin : g_chk
        p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            (rise_st[i] && !(clr_we && clr_rise[i])) |=> rise_st[i]);
        p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
            (fall_ev[i] || rise_ev[i]) |=> (fall_st[i] || rise_st[i]));
        p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
            (!rise_ev[i] && !rise_st[i]) |=> !rise_st[i]);
    end

endmodule

// File: rtl/therm_irq_ctrl.sv
module therm_irq_ctrl
    import therm_pkg::*;
#(
    parameter int N_LEV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_stb,
    input  logic [7:0]        sensor_code,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    localparam int LEV = (N_LEV > MAX_LEV) ? MAX_LEV : N_LEV;

    logic              core_on;
    logic [1:0]        ctrl_q;
    logic [DATA_W-1:0] rise_q;
    logic [DATA_W-1:0] fall_q;
    logic [DATA_W-1:0] ien_q;
    emul_t             emul_q;
    code_t             temp_q;
    code_t             cur_code;
    logic              accept;
    logic [LEV-1:0]    rise_ev;
    logic [LEV-1:0]    fall_ev;
    logic [LEV-1:0]    rise_st;
    logic [LEV-1:0]    fall_st;
    logic [LEV-1:0]    clr_rise;
    logic [LEV-1:0]    clr_fall;
    logic [LEV-1:0]    en_rise;
    logic [LEV-1:0]    en_fall;
    logic [DATA_W-1:0] stat_w;
    logic              clr_we;

    assign clr_we = reg_we && (reg_addr == A_ICLR);

    therm_regs #(.N_LEV(LEV)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_we),
        .wr_addr     (reg_addr),
        .wr_data     (reg_wdata),
        .sample_stb  (sample_stb),
        .sensor_code (sensor_code),
        .core_on     (core_on),
        .ctrl_q      (ctrl_q),
        .rise_q      (rise_q),
        .fall_q      (fall_q),
        .ien_q       (ien_q),
        .emul_q      (emul_q),
        .temp_q      (temp_q),
        .cur_code    (cur_code),
        .accept      (accept)
    );

    therm_cmp #(.N_LEV(LEV)) u_cmp (
        .fire      (accept),
        .prev_code (temp_q),
        .new_code  (cur_code),
        .rise_thr  (rise_q),
        .fall_thr  (fall_q),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev)
    );

    for (genvar i = 0; i < LEV; i++) begin : g_map
        assign clr_rise[i] = reg_wdata[LANE*i];
        assign clr_fall[i] = reg_wdata[FALL_OFS+LANE*i];
        assign en_rise[i]  = ien_q[LANE*i];
        assign en_fall[i]  = ien_q[FALL_OFS+LANE*i];
    end

    always_comb begin
        stat_w = '0;
        for (int i = 0; i < LEV; i++) begin
            stat_w[LANE*i]          = rise_st[i];
            stat_w[FALL_OFS+LANE*i] = fall_st[i];
        end
    end

    therm_stat #(.N_LEV(LEV)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .clr_we   (clr_we),
        .clr_rise (clr_rise),
        .clr_fall (clr_fall),
        .en_rise  (en_rise),
        .en_fall  (en_fall),
        .core_on  (core_on),
        .rise_st  (rise_st),
        .fall_st  (fall_st),
        .irq      (irq)
    );

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {{(DATA_W-2){1'b0}}, ctrl_q};
            A_CORE:  reg_rdata = {{(DATA_W-1){1'b0}}, core_on};
            A_TEMP:  reg_rdata = {{(DATA_W-CODE_W){1'b0}}, temp_q};
            A_RISE:  reg_rdata = rise_q;
            A_FALL:  reg_rdata = fall_q;
            A_IEN:   reg_rdata = ien_q;
            A_IST:   reg_rdata = stat_w;
            A_EMUL:  reg_rdata = emul_q;
            default: reg_rdata = '0;
        endcase
    end

    p_off_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (!core_on && !clr_we) |=> $stable(stat_w));

endmodule

// File: tb/sim_therm_irq_ctrl.sv
module sim_therm_irq_ctrl;
    import therm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic [7:0]  sens = 8'd0;
    logic [7:0]  addr = 8'h74;
    logic        we = 1'b0;
    logic [31:0] wd = 32'd0;
    logic [31:0] rd;
    logic        irq;

    always #5 clk = ~clk;

    therm_irq_ctrl u0 (
        .clk(clk), .rst(rst), .sample_stb(stb), .sensor_code(sens),
        .reg_addr(addr), .reg_we(we), .reg_wdata(wd), .reg_rdata(rd), .irq(irq)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // behavioural reference state
    logic [1:0]  m_ctrl;
    logic [31:0] m_rise, m_fall, m_en, m_stat, m_emul;
    logic [7:0]  m_temp;
    int          m_cnt;

    always @(posedge clk) begin
        logic [31:0] ev;
        logic [7:0]  code;
        int          thr;
        if (rst) begin
            m_ctrl = 2'd2; m_rise = 0; m_fall = 0; m_en = 0;
            m_stat = 0; m_emul = 0; m_temp = 0; m_cnt = 0;
        end else begin
            ev = 0;
            if (stb && m_ctrl == 2'd3) begin
                code = (m_emul[0] && m_cnt == 0) ? m_emul[15:8] : sens;
                for (int i = 0; i < 4; i++) begin
                    thr = int'(m_rise[8*i +: 8]);
                    if (int'(code) >= thr && int'(m_temp) < thr) ev[4*i] = 1'b1;
                    thr = int'(m_fall[8*i +: 8]);
                    if (thr != 0 && int'(code) < thr && int'(m_temp) >= thr) ev[16+4*i] = 1'b1;
                end
                m_temp = code;
                if (m_cnt != 0 && !(we && addr == 8'h80)) m_cnt = m_cnt - 1;
            end
            if (we) begin
                case (addr)
                    8'h20: m_ctrl = wd[1:0];
                    8'h50: m_rise = wd;
                    8'h54: m_fall = wd;
                    8'h70: m_en   = wd & 32'h1111_1111;
                    8'h78: m_stat = m_stat & ~wd;
                    8'h80: begin m_emul = wd; m_cnt = int'(wd[31:16]); end
                    default: ;
                endcase
            end
            m_stat = m_stat | ev;
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h20: return {30'd0, m_ctrl};
            8'h28: return {31'd0, m_ctrl == 2'd3};
            8'h40: return {24'd0, m_temp};
            8'h50: return m_rise;
            8'h54: return m_fall;
            8'h70: return m_en;
            8'h74: return m_stat;
            8'h80: return m_emul;
            default: return 32'd0;
        endcase
    endfunction

    // compare after every clock edge, away from the edge itself
    always @(posedge clk) begin
        logic exp_irq;
        #2;
        exp_irq = (m_ctrl == 2'd3) && ((m_stat & m_en) != 0);
        checks++;
        if (rd !== m_read(addr)) begin
            errors++;
            $display("FAIL %s rdata@%h actual %h expected %h", tag, addr, rd, m_read(addr));
        end
        checks++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp_irq);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 8'h74;
    endtask

    task automatic smp(input logic [7:0] c);
        sens = c; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic look(input logic [7:0] a);
        addr = a;
        @(negedge clk);
        addr = 8'h74;
    endtask

    task automatic read_all;
        look(8'h20); look(8'h28); look(8'h40); look(8'h50);
        look(8'h54); look(8'h70); look(8'h74); look(8'h78);
        look(8'h80); look(8'h3C);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1"; read_all();

        tag = "R10";
        wr(8'h50, 32'h00_6E_67_55);   // up: 85, 103, 110, 0
        wr(8'h54, 32'h00_64_5D_4B);   // down: 75, 93, 100, none
        wr(8'h70, 32'hFFFF_FFFF);
        read_all();

        tag = "R2";
        smp(8'd120); look(8'h40);
        wr(8'h20, 32'd1); smp(8'd120); look(8'h40); look(8'h28);
        wr(8'h20, 32'd3); look(8'h28);

        tag = "R3"; smp(8'd60); look(8'h40); smp(8'd70); look(8'h40);

        tag = "R4";
        smp(8'd84); smp(8'd85); smp(8'd90); smp(8'd104); smp(8'd112); smp(8'd130);
        look(8'h40);

        tag = "R6";
        wr(8'h78, 32'h0000_0000);
        wr(8'h78, 32'h0000_0111);
        smp(8'd131); smp(8'd125);

        tag = "R5";
        smp(8'd99); smp(8'd80); smp(8'd50);
        wr(8'h78, 32'h0011_0000);
        wr(8'h54, 32'h0000_5D_4B);
        smp(8'd120); smp(8'd40);
        wr(8'h78, 32'hFFFF_FFFF);

        tag = "R7";
        smp(8'd10);
        addr = 8'h78; wd = 32'h0001_0001; we = 1'b1; sens = 8'd86; stb = 1'b1;
        @(negedge clk);
        we = 1'b0; stb = 1'b0; addr = 8'h74;
        look(8'h74);

        tag = "R8";
        wr(8'h70, 32'h0000_0100);
        smp(8'd105);
        wr(8'h70, 32'h0000_0000);
        smp(8'd111);
        wr(8'h70, 32'h0000_0100);
        wr(8'h78, 32'h0000_0100);
        wr(8'h70, 32'h1111_1111);
        wr(8'h78, 32'hFFFF_FFFF);

        tag = "R9";
        smp(8'd40);
        wr(8'h80, {16'd3, 8'd120, 8'h01});
        look(8'h80);
        smp(8'd50); look(8'h40); smp(8'd51); smp(8'd52); look(8'h40);
        smp(8'd53); look(8'h40); smp(8'd54); look(8'h40);
        wr(8'h80, {16'd0, 8'd120, 8'h00});
        smp(8'd55); look(8'h40);
        wr(8'h80, {16'd0, 8'd90, 8'h01});
        smp(8'd20); look(8'h40);
        wr(8'h80, 32'd0);

        tag = "R2";
        smp(8'd130);
        wr(8'h20, 32'd2); look(8'h28);
        smp(8'd10); smp(8'd200); look(8'h40); look(8'h74);
        wr(8'h20, 32'd3);

        tag = "R10"; read_all();

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule